// File: doc/BRIEF.md
# Latched-Address Pseudo-SRAM Memory Emulator

This block is a clock-synchronous model of a 16-bit-wide memory device whose pins follow an asynchronous pseudo-SRAM convention. There are two chip selects (one active low, one active high), a write strobe, a read strobe and two active-low byte-lane enables. A fast system clock samples every pin through a two-flop synchroniser. All edge events are taken from the synchronised copies.

An access begins when the second of the two chip selects becomes active. At that moment the block captures the address, and the captured address is held for the rest of the access. While the part stays selected, a falling read strobe or a falling write strobe captures a new address, which gives a strobe-controlled access mode. A write on the write-strobe edge also takes the data. Writes update only the enabled byte lanes. Read data is presented as a data vector plus a per-lane output-enable vector, so high impedance is visible as a deasserted enable.

Each access must be followed by a deselected gap of at least `PRE_CYC` clock cycles. If a selection arrives before the gap is complete, it is ignored for the whole of that selection: nothing is written and nothing is driven. The block also sets a sticky violation flag, which only reset clears. The depth is set by `AW`. The default is 1K words so that the default build stays small. `AW = 16` gives a 64K-word part.

Top module: `psram_emu`

## Requirements
- R1: After reset, `dout_oe_o` is 2'b00 and `viol_o` is 0.
- R2: When `cs_n_i` is high (standby) or `cs_i` is low (precharge), no lane is driven: `dout_oe_o` is 2'b00 within 3 clock cycles. This holds even with `rd_n_i` low.
- R3: The address is captured when selection completes, by either the falling edge of `cs_n_i` or the rising edge of `cs_i`. After that, a change on `addr_i` with no strobe edge does not change the word read.
- R4: During a read (`cs_n_i`=0, `cs_i`=1, `wr_n_i`=1, `rd_n_i`=0), `dout_oe_o[k]` is 1 exactly when `bl_n_i[k]` is 0. Lane 0 is `dout_o[7:0]` and lane 1 is `dout_o[15:8]`.
- R5: A write stores only the lanes whose `bl_n_i` bit is 0. The other lane of the word keeps its old value. A write where `wr_n_i` is already low at the selection edge uses the captured address and the `din_i` value present at that edge.
- R6: While the part is selected with `wr_n_i`=1, a falling edge of `rd_n_i` captures a new address from `addr_i`.
- R7: While the part is selected, a falling edge of `wr_n_i` captures the address and `din_i` and writes them, with lane masking as in R5.
- R8: A selection that begins fewer than `PRE_CYC` synchronised cycles after the end of the previous access is ignored until deselection: no write and no drive. It sets `viol_o`, and `viol_o` stays 1 until reset.
- R9: A selection that begins after a full precharge gap is accepted normally, including after an ignored selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe (output enable), active low |
| bl_n_i | input | 2 | Byte-lane enables, active low; bit 0 = low byte |
| addr_i | input | AW | Word address |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data, zero when not driven |
| dout_oe_o | output | 2 | Per-lane drive enable; 0 = high impedance |
| viol_o | output | 1 | Sticky precharge-violation flag |

## Verification
A corrupted captured address, or a wrong access state, shows up as wrong read data or a wrong lane enable three cycles after the pins change, because of the two synchroniser stages plus the state register. A corrupted byte mask does not show up at once. It appears only on a later read of the same word, so every masked write is followed by a read-back of both lanes. A broken precharge counter shows up either as a write that should have been ignored but is visible on the next accepted read, or as `viol_o` taking the wrong value right after a short deselect.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_BLOCK  = 2'd2
  } acc_state_e;
endpackage

// File: rtl/psram_sync.sv
module psram_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned AW    = 10,
  parameter int unsigned LANES = 2,
  localparam int unsigned LW    = psram_pkg::LANE_W,
  localparam int unsigned DW    = LANES * LW,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  // One storage array per lane keeps each lane's write port separate
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[l]) mem[waddr_i] <= wdata_i[l*LW +: LW];
    end

    assign rdata_o[l*LW +: LW] = mem[raddr_i];
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned PRE_CYC = 4,
  localparam int unsigned CW     = $clog2(PRE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_n_i,
  input  logic          rd_n_i,
  input  logic [AW-1:0] addr_i,
  output logic          we_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          drive_o,
  output logic          blocked_o,
  output logic          viol_o
);
  localparam logic [CW-1:0] PRE_MAX = CW'(PRE_CYC);

  acc_state_e    state_q;
  logic          sel_q, wr_n_q, rd_n_q, viol_q;
  logic [CW-1:0] pc_cnt_q;
  logic [AW-1:0] lat_addr_q;
  logic          sel_rise, wr_fall, rd_fall, pc_ok;

  assign sel_rise = sel_i & ~sel_q;
  assign wr_fall  = ~wr_n_i & wr_n_q;
  assign rd_fall  = ~rd_n_i & rd_n_q;
  assign pc_ok    = (pc_cnt_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      sel_q  <= sel_i;
      wr_n_q <= wr_n_i;
      rd_n_q <= rd_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pc_cnt_q   <= PRE_MAX;
      lat_addr_q <= '0;
      viol_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sel_rise) begin
            if (pc_ok) begin
              state_q    <= ST_ACTIVE;
              lat_addr_q <= addr_i;
            end else begin
              state_q <= ST_BLOCK;
              viol_q  <= 1'b1;
            end
          end else if (!sel_i && !pc_ok) begin
            pc_cnt_q <= pc_cnt_q + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (!sel_i) begin
            state_q  <= ST_IDLE;
            pc_cnt_q <= '0;
          end else if (wr_fall || (rd_fall && wr_n_i)) begin
            lat_addr_q <= addr_i;
          end
        end
        ST_BLOCK: begin
          // an ignored attempt restarts the gap
          if (!sel_i) begin
            state_q  <= ST_IDLE;
            pc_cnt_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign we_o = ((state_q == ST_IDLE) && sel_rise && pc_ok && !wr_n_i) ||
                ((state_q == ST_ACTIVE) && sel_i && wr_fall);
  assign rd_addr_o = lat_addr_q;
  assign drive_o   = (state_q == ST_ACTIVE) && !rd_n_i && wr_n_i;
  assign blocked_o = (state_q == ST_BLOCK);
  assign viol_o    = viol_q;
endmodule

// File: rtl/psram_emu.sv
module psram_emu #(
  parameter int unsigned AW      = 10,
  parameter int unsigned PRE_CYC = 4,
  localparam int unsigned LANES  = 2,
  localparam int unsigned DW     = LANES * psram_pkg::LANE_W,
  localparam int unsigned CTL_W  = 4 + LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             cs_i,
  input  logic             wr_n_i,
  input  logic             rd_n_i,
  input  logic [LANES-1:0] bl_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o,
  output logic [LANES-1:0] dout_oe_o,
  output logic             viol_o
);
  logic             cs_n_s, cs_s, wr_n_s, rd_n_s, sel_s;
  logic [LANES-1:0] bl_n_s;
  logic [AW-1:0]    addr_s, rd_addr;
  logic [DW-1:0]    din_s, rdata;
  logic             mem_we, drive, blocked;

  psram_sync #(
    .W  (CTL_W),
    .RST({1'b1, 1'b0, 1'b1, 1'b1, {LANES{1'b1}}})
  ) i_sync_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_n_i, cs_i, wr_n_i, rd_n_i, bl_n_i}),
    .q_o   ({cs_n_s, cs_s, wr_n_s, rd_n_s, bl_n_s})
  );

  // buses share the control delay so they stay aligned
  psram_sync #(.W(AW + DW), .RST('0)) i_sync_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, din_i}),
    .q_o   ({addr_s, din_s})
  );

  assign sel_s = ~cs_n_s & cs_s;

  psram_ctrl #(.AW(AW), .PRE_CYC(PRE_CYC)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_s),
    .wr_n_i   (wr_n_s),
    .rd_n_i   (rd_n_s),
    .addr_i   (addr_s),
    .we_o     (mem_we),
    .rd_addr_o(rd_addr),
    .drive_o  (drive),
    .blocked_o(blocked),
    .viol_o   (viol_o)
  );

  psram_array #(.AW(AW), .LANES(LANES)) i_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .mask_i (~bl_n_s),
    .waddr_i(addr_s),
    .wdata_i(din_s),
    .raddr_i(rd_addr),
    .rdata_o(rdata)
  );

  assign dout_oe_o = {LANES{drive}} & ~bl_n_s;
  assign dout_o    = drive ? rdata : '0;
endmodule

// File: rtl/psram_emu_chk.sv
module psram_emu_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_s,
  input logic             wr_n_s,
  input logic             mem_we,
  input logic             blocked,
  input logic [LANES-1:0] dout_oe_o,
  input logic             viol_o
);
  p_deselect_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |=> (dout_oe_o == '0));

  p_no_drive_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dout_oe_o) |-> !mem_we);

  p_write_when_selected_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (sel_s && !wr_n_s));

  p_blocked_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |-> !mem_we);

  p_viol_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  p_viol_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_o) |-> $past(sel_s));
endmodule

bind psram_emu psram_emu_chk #(.LANES(LANES)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_s    (sel_s),
  .wr_n_s   (wr_n_s),
  .mem_we   (mem_we),
  .blocked  (blocked),
  .dout_oe_o(dout_oe_o),
  .viol_o   (viol_o)
);

// File: tb/test_psram_emu.sv
module test_psram_emu;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cs = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0]    bl_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0, dout;
  logic [1:0]    dout_oe;
  logic          viol;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic exp_viol = 1'b0;
  logic [15:0] model [int];

  string       q_req [$];
  logic [15:0] q_d   [$];
  logic [1:0]  q_oe  [$];
  logic        q_v   [$];
  event chk_ev;

  always #10 clk = ~clk;

  psram_emu #(.AW(AW), .PRE_CYC(4)) i_psram_emu (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .cs_i(cs), .wr_n_i(wr_n),
    .rd_n_i(rd_n), .bl_n_i(bl_n), .addr_i(addr), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .viol_o(viol)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [15:0] d, logic [1:0] oe);
    q_req.push_back(req); q_d.push_back(d); q_oe.push_back(oe); q_v.push_back(exp_viol);
    -> chk_ev;
    #1;
  endtask

  task automatic model_wr(int a, logic [15:0] d, logic [1:0] m_n);
    logic [15:0] w;
    w = model.exists(a) ? model[a] : 16'h0;
    for (int l = 0; l < 2; l++) if (!m_n[l]) w[l*8 +: 8] = d[l*8 +: 8];
    model[a] = w;
  endtask

  task automatic deselect(int n);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    tick(n);
  endtask

  // write with strobe low before selection completes
  task automatic sel_write(int a, logic [15:0] d, logic [1:0] m_n);
    addr = AW'(a); din = d; bl_n = m_n; wr_n = 1'b0; rd_n = 1'b1; cs = 1'b1;
    tick(1);
    cs_n = 1'b0;
    tick(5);
    model_wr(a, d, m_n);
  endtask

  task automatic sel_read(int a, logic [1:0] m_n);
    addr = AW'(a); bl_n = m_n; wr_n = 1'b1; rd_n = 1'b0; cs = 1'b1;
    tick(1);
    cs_n = 1'b0;
    tick(5);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      string r; logic [15:0] d; logic [1:0] oe; logic v; logic [15:0] m;
      @(chk_ev);
      while (q_req.size() > 0) begin
        r = q_req.pop_front(); d = q_d.pop_front(); oe = q_oe.pop_front(); v = q_v.pop_front();
        m = {{8{oe[1]}}, {8{oe[0]}}};
        n_run++;
        if (dout_oe !== oe || viol !== v || (dout & m) !== (d & m)) begin
          n_fail++;
          $display("FAIL %s: got d=%h oe=%b viol=%b exp d=%h oe=%b viol=%b",
                   r, dout & m, dout_oe, viol, d & m, oe, v);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_out("R1 reset", 16'h0, 2'b00);

    sel_write(5, 16'h1234, 2'b00);
    deselect(10);
    sel_read(5, 2'b00);
    expect_out("R4 both lanes", model[5], 2'b11);
    bl_n = 2'b10; tick(5);
    expect_out("R4 low lane only", model[5], 2'b01);
    bl_n = 2'b01; tick(5);
    expect_out("R4 high lane only", model[5], 2'b10);
    bl_n = 2'b00;
    addr = AW'(9); tick(5);
    expect_out("R3 addr held after CE1 edge", model[5], 2'b11);
    cs_n = 1'b1; tick(5);
    expect_out("R2 standby with rd low", 16'h0, 2'b00);
    deselect(10);

    sel_write(5, 16'hABCD, 2'b01);
    deselect(10);
    sel_read(5, 2'b00);
    expect_out("R5 masked write keeps low lane", 16'hAB34, 2'b11);
    deselect(10);

    // precharge via active-high select, then CE2 rising edge
    cs = 1'b0; addr = AW'(5); bl_n = 2'b00; rd_n = 1'b0; tick(1);
    cs_n = 1'b0; tick(5);
    expect_out("R2 precharge with rd low", 16'h0, 2'b00);
    cs = 1'b1; tick(2); addr = AW'(9); tick(4);
    expect_out("R3 addr latched on CE2 edge", model[5], 2'b11);
    deselect(10);

    // strobe-controlled accesses while selected
    addr = AW'(5); cs = 1'b1; tick(1);
    cs_n = 1'b0; tick(5);
    addr = AW'(20); din = 16'h5A5A; bl_n = 2'b00; wr_n = 1'b0; tick(5);
    model_wr(20, 16'h5A5A, 2'b00);
    wr_n = 1'b1; addr = AW'(5); tick(2);
    din = 16'hC3C3; addr = AW'(21); bl_n = 2'b10; wr_n = 1'b0; tick(5);
    model_wr(21, 16'hC3C3, 2'b10);
    wr_n = 1'b1; bl_n = 2'b00; addr = AW'(20); tick(2);
    rd_n = 1'b0; tick(5);
    expect_out("R7 write on WE edge", model[20], 2'b11);
    rd_n = 1'b1; addr = AW'(5); tick(2);
    rd_n = 1'b0; tick(5);
    expect_out("R6 addr relatched on OE edge", model[5], 2'b11);
    rd_n = 1'b1; addr = AW'(21); tick(2);
    rd_n = 1'b0; tick(5);
    expect_out("R7 masked WE write low lane", 16'h00C3, 2'b11);

    // short gap: ignored selection
    deselect(2);
    addr = AW'(5); din = 16'hFFFF; bl_n = 2'b00; wr_n = 1'b0;
    cs_n = 1'b0; tick(5);
    exp_viol = 1'b1;
    expect_out("R8 short gap flagged, no drive", 16'h0, 2'b00);
    wr_n = 1'b1; rd_n = 1'b0; tick(5);
    expect_out("R8 blocked read not driven", 16'h0, 2'b00);
    deselect(10);
    sel_read(5, 2'b00);
    expect_out("R9 accepted after gap, R8 write dropped", 16'hAB34, 2'b11);
    deselect(10);
    expect_out("R8 flag sticky", 16'h0, 2'b00);

    sel_write(7, 16'h0F0F, 2'b10);
    deselect(10);
    sel_read(7, 2'b00);
    expect_out("R5 low lane only write", model[7], 2'b11);
    deselect(5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule